// File: doc/BRIEF.md
# Predicated Vector Reduction Sequencer

This block folds the enabled elements of an eight-element source vector into a single 32-bit scalar. It handles one element per clock, from the lowest index to the highest. A predicate mask chooses the elements that take part. A 3-bit selector chooses the binary operation: add, bitwise AND, OR or XOR, signed minimum or signed maximum. The final value is written into the destination vector at the lowest enabled index. The same value also appears on a result port.

The destination element at the lowest enabled index holds the running accumulator throughout the fold. Together with the exported source and destination offsets, that element is all the state needed to continue after an interrupt. When the interrupt input is raised, the sequencer halts with its offsets frozen. A resume pulse then continues the fold: the accumulator is reloaded from the destination element and the scan carries on from the saved source offset.

When the record flag is set, the block also builds a 4-bit condition summary from every partial result. The any/all mode bit decides how those per-result conditions are merged.

Top module: `vred_seq`

## Requirements
- R1: After a reduction with a non-zero mask, `result` and destination element `dst_off` (the index of the lowest set mask bit) both equal the left-to-right fold of the enabled source elements. The fold starts from the lowest enabled element.
- R2: `op` selects the operation: 0 add (modulo 2^32), 1 AND, 2 OR, 3 XOR, 4 signed minimum, 5 signed maximum. Values 6 and 7 behave as add.
- R3: Destination elements whose mask bit is 0 are never modified by a reduction.
- R4: With `rec`=1 and `all_mode`=0, `cond` is the bitwise OR of the condition code of every partial result. A partial result is the accumulator after each enabled element. The condition code is {LT, GT, EQ, 0} in bits [3:0], from a signed comparison with zero.
- R5: With `rec`=1 and `all_mode`=1, `cond` is the bitwise AND of those condition codes.
- R6: With `rec`=0, `cond` reads 0 after the reduction.
- R7: An all-zero mask completes with `done` in the cycle after `start`. No destination element is written, and `cond` and `result` read 0.
- R8: A high `irq` while busy stops the scan before the current element is processed. The block enters the halted state, and `src_off` and `dst_off` hold still until `resume`. The resumed reduction gives the same result as an uninterrupted one.
- R9: Without interrupts, `busy` is high for the eight cycles after `start`. `done` then pulses for exactly one cycle. `start`, and loads through `ld_en`, are ignored unless `busy`, `halted` and `done` are all low.
- R10: In the first busy cycle, `src_off` is 0 and `dst_off` is the index of the lowest set bit of the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Write one vector element while idle |
| ld_dst | input | 1 | Load target: 0 source vector, 1 destination vector |
| ld_idx | input | 3 | Element index for load |
| ld_data | input | 32 | Element value for load |
| rd_dst | input | 1 | Read target: 0 source vector, 1 destination vector |
| rd_idx | input | 3 | Element index for read |
| rd_data | output | 32 | Combinational read data |
| start | input | 1 | Begin a reduction with the operands below |
| op | input | 3 | Operation select |
| mask | input | 8 | Predicate mask, bit i enables element i |
| rec | input | 1 | Record flag for the condition summary |
| all_mode | input | 1 | 0 merges conditions as any, 1 as all |
| irq | input | 1 | Interrupt: halt the scan |
| resume | input | 1 | Continue a halted scan |
| busy | output | 1 | Scan in progress |
| halted | output | 1 | Scan suspended by interrupt |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Final reduced value |
| cond | output | 4 | Condition summary {LT, GT, EQ, 0} |
| src_off | output | 3 | Next source element to process |
| dst_off | output | 3 | Destination element holding the accumulator |

## Verification
The assertions assume that nothing changes the destination vector while the sequencer is halted. Resume correctness depends on this, because the saved accumulator lives in that vector. The bench holds to this by issuing no loads between `irq` and `resume`. The assertions also assume that `irq` and `resume` are single-cycle pulses, given only in the busy and halted states respectively. The bench raises every control input at a falling edge and lowers it one cycle later.

// File: rtl/vred_seq.sv
module vred_seq #(
  parameter int VL = 8,
  parameter int W  = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ld_en,
  input  logic                    ld_dst,
  input  logic [$clog2(VL)-1:0]   ld_idx,
  input  logic [W-1:0]            ld_data,
  input  logic                    rd_dst,
  input  logic [$clog2(VL)-1:0]   rd_idx,
  output logic [W-1:0]            rd_data,
  input  logic                    start,
  input  logic [2:0]              op,
  input  logic [VL-1:0]           mask,
  input  logic                    rec,
  input  logic                    all_mode,
  input  logic                    irq,
  input  logic                    resume,
  output logic                    busy,
  output logic                    halted,
  output logic                    done,
  output logic [W-1:0]            result,
  output logic [3:0]              cond,
  output logic [$clog2(VL)-1:0]   src_off,
  output logic [$clog2(VL)-1:0]   dst_off
);
  localparam int IW = $clog2(VL);
  localparam logic [IW-1:0] LAST = IW'(VL - 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_HALT, S_DONE} state_t;
  state_t state;

  logic [W-1:0]  src_vec [VL];
  logic [W-1:0]  dst_vec [VL];
  logic [W-1:0]  acc;
  logic [2:0]    op_q;
  logic [VL-1:0] mask_q;
  logic          rec_q, all_q;
  logic [3:0]    cond_q;

  function automatic logic [IW-1:0] lowest_set(input logic [VL-1:0] m);
    logic [IW-1:0] r;
    r = '0;
    for (int i = VL - 1; i >= 0; i--)
      if (m[i]) r = IW'(i);
    return r;
  endfunction

  function automatic logic [W-1:0] combine(input logic [2:0] o, input logic [W-1:0] a, input logic [W-1:0] b);
    case (o)
      3'd1:    return a & b;
      3'd2:    return a | b;
      3'd3:    return a ^ b;
      3'd4:    return ($signed(a) < $signed(b)) ? a : b;
      3'd5:    return ($signed(a) > $signed(b)) ? a : b;
      default: return a + b;
    endcase
  endfunction

  function automatic logic [3:0] ccode(input logic [W-1:0] v);
    return {$signed(v) < 0, $signed(v) > 0, v == '0, 1'b0};
  endfunction

  wire          is_first = (src_off == dst_off);
  wire          en_now   = mask_q[src_off];
  wire [W-1:0]  elem     = src_vec[src_off];
  wire [W-1:0]  nxt      = is_first ? elem : combine(op_q, acc, elem);
  wire [3:0]    nxt_cc   = ccode(nxt);
  wire [3:0]    merged   = is_first ? nxt_cc : (all_q ? (cond_q & nxt_cc) : (cond_q | nxt_cc));
  wire [W-1:0]  final_v  = en_now ? nxt : acc;

  assign busy    = (state == S_RUN);
  assign halted  = (state == S_HALT);
  assign done    = (state == S_DONE);
  assign cond    = cond_q;
  assign rd_data = rd_dst ? dst_vec[rd_idx] : src_vec[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      acc     <= '0;
      op_q    <= '0;
      mask_q  <= '0;
      rec_q   <= 1'b0;
      all_q   <= 1'b0;
      cond_q  <= '0;
      result  <= '0;
      src_off <= '0;
      dst_off <= '0;
      for (int i = 0; i < VL; i++) begin
        src_vec[i] <= '0;
        dst_vec[i] <= '0;
      end
    end else begin
      case (state)
        S_IDLE: begin
          if (ld_en) begin
            if (ld_dst) dst_vec[ld_idx] <= ld_data;
            else        src_vec[ld_idx] <= ld_data;
          end
          if (start) begin
            op_q    <= op;
            mask_q  <= mask;
            rec_q   <= rec;
            all_q   <= all_mode;
            cond_q  <= '0;
            src_off <= '0;
            dst_off <= lowest_set(mask);
            if (mask == '0) begin
              result <= '0;
              state  <= S_DONE;
            end else begin
              state  <= S_RUN;
            end
          end
        end
        S_RUN: begin
          if (irq) begin
            state <= S_HALT;
          end else begin
            if (en_now) begin
              dst_vec[dst_off] <= nxt;
              acc              <= nxt;
              if (rec_q) cond_q <= merged;
            end
            if (src_off == LAST) begin
              result <= final_v;
              state  <= S_DONE;
            end else begin
              src_off <= src_off + 1'b1;
            end
          end
        end
        S_HALT: begin
          if (resume) begin
            acc   <= dst_vec[dst_off];
            state <= S_RUN;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < VL; g++) begin : g_keep
    p_masked_dst_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state != S_IDLE && !mask_q[g]) |=> $stable(dst_vec[g]))
      else $error("masked-out destination element %0d changed", g);
  end

  p_offsets_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !resume) |=> ($stable(src_off) && $stable(dst_off)))
    else $error("offsets moved while halted");

  p_empty_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && start && mask == '0) |=> (done && cond == 4'd0))
    else $error("empty mask did not complete at once");

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done)
    else $error("done held longer than one cycle");

  p_dst_enabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || halted) |-> mask_q[dst_off])
    else $error("destination offset points at a masked-out element");

  p_cond_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((busy || done) && !rec_q) |-> (cond == 4'd0))
    else $error("condition recorded with record flag low");
endmodule

// File: tb/test_vred_seq.sv
`timescale 1ns/1ps
module test_vred_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_en = 1'b0, ld_dst = 1'b0, rd_dst = 1'b0;
  logic [2:0]  ld_idx = '0, rd_idx = '0;
  logic [31:0] ld_data = '0;
  logic        start = 1'b0, rec = 1'b0, all_mode = 1'b0, irq = 1'b0, resume = 1'b0;
  logic [2:0]  op = '0;
  logic [7:0]  mask = '0;
  logic [31:0] rd_data, result;
  logic        busy, halted, done;
  logic [3:0]  cond;
  logic [2:0]  src_off, dst_off;

  int checks = 0;
  int errors = 0;
  logic [31:0] sv [8];
  logic [31:0] dv [8];
  int    n_cyc;
  logic  b_first;
  logic [2:0] so_first, do_first;

  always #2.5 clk = ~clk;

  vred_seq i_vred_seq (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_dst(ld_dst), .ld_idx(ld_idx),
    .ld_data(ld_data), .rd_dst(rd_dst), .rd_idx(rd_idx), .rd_data(rd_data),
    .start(start), .op(op), .mask(mask), .rec(rec), .all_mode(all_mode),
    .irq(irq), .resume(resume), .busy(busy), .halted(halted), .done(done),
    .result(result), .cond(cond), .src_off(src_off), .dst_off(dst_off)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_comb(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b);
    case (o)
      3'd1: return a & b;
      3'd2: return a | b;
      3'd3: return a ^ b;
      3'd4: return ($signed(a) < $signed(b)) ? a : b;
      3'd5: return ($signed(a) > $signed(b)) ? a : b;
      default: return a + b;
    endcase
  endfunction

  function automatic logic [3:0] m_cc(input logic [31:0] v);
    return {$signed(v) < 0, $signed(v) > 0, v == 32'd0, 1'b0};
  endfunction

  function automatic logic [31:0] m_fold(input logic [2:0] o, input logic [7:0] m);
    logic [31:0] a;
    bit first;
    a = '0; first = 1;
    for (int i = 0; i < 8; i++)
      if (m[i]) begin
        a = first ? sv[i] : m_comb(o, a, sv[i]);
        first = 0;
      end
    return a;
  endfunction

  function automatic logic [3:0] m_cond(input logic [2:0] o, input logic [7:0] m, input bit all);
    logic [31:0] a;
    logic [3:0] c;
    bit first;
    a = '0; c = '0; first = 1;
    for (int i = 0; i < 8; i++)
      if (m[i]) begin
        a = first ? sv[i] : m_comb(o, a, sv[i]);
        c = first ? m_cc(a) : (all ? (c & m_cc(a)) : (c | m_cc(a)));
        first = 0;
      end
    return c;
  endfunction

  function automatic int low_bit(input logic [7:0] m);
    for (int i = 0; i < 8; i++) if (m[i]) return i;
    return 0;
  endfunction

  task automatic load(input bit to_dst, input int idx, input logic [31:0] val);
    @(negedge clk);
    ld_en = 1'b1; ld_dst = to_dst; ld_idx = 3'(idx); ld_data = val;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic load_all();
    for (int i = 0; i < 8; i++) load(1'b0, i, sv[i]);
    for (int i = 0; i < 8; i++) load(1'b1, i, dv[i]);
  endtask

  task automatic read_dst(input int idx, output logic [31:0] v);
    rd_dst = 1'b1; rd_idx = 3'(idx);
    #0.1;
    v = rd_data;
  endtask

  task automatic run(input logic [2:0] o, input logic [7:0] m, input bit r, input bit a);
    @(negedge clk);
    start = 1'b1; op = o; mask = m; rec = r; all_mode = a;
    @(negedge clk);
    start = 1'b0;
    n_cyc = 1; b_first = busy; so_first = src_off; do_first = dst_off;
    while (!done && n_cyc < 100) begin
      @(negedge clk);
      n_cyc++;
    end
  endtask

  task automatic t_reset();
    chk(!busy && !halted && !done, "R9 reset idle", {29'd0, busy, halted, done}, 32'd0);
    chk(cond == 4'd0 && result == 32'd0, "R6 reset cond/result", result, 32'd0);
    chk(src_off == 3'd0 && dst_off == 3'd0, "R10 reset offsets", {26'd0, src_off, dst_off}, 32'd0);
  endtask

  task automatic t_basic_add();
    logic [31:0] v;
    logic [7:0]  m = 8'hB4;
    for (int i = 0; i < 8; i++) begin
      sv[i] = 32'h100 * (i + 1) + 32'(i);
      dv[i] = 32'hDEAD_0000 | 32'(i);
    end
    load_all();
    run(3'd0, m, 1'b0, 1'b0);
    chk(n_cyc == 9, "R9 done timing", 32'(n_cyc), 32'd9);
    chk(b_first == 1'b1, "R9 busy after start", {31'd0, b_first}, 32'd1);
    chk(so_first == 3'd0, "R10 src_off start", {29'd0, so_first}, 32'd0);
    chk(do_first == 3'd2, "R10 dst_off first set bit", {29'd0, do_first}, 32'd2);
    chk(result == m_fold(3'd0, m), "R1 add result", result, m_fold(3'd0, m));
    read_dst(2, v);
    chk(v == m_fold(3'd0, m), "R1 result in first enabled dst", v, m_fold(3'd0, m));
    for (int i = 0; i < 8; i++)
      if (!m[i]) begin
        read_dst(i, v);
        chk(v == dv[i], "R3 masked-out dst kept", v, dv[i]);
      end
    @(negedge clk);
    chk(!done && !busy, "R9 done one cycle", {30'd0, done, busy}, 32'd0);
  endtask

  task automatic t_ops();
    logic [7:0] ms [2];
    ms[0] = 8'hFF; ms[1] = 8'h5A;
    sv[0] = 32'h0000_00F3; sv[1] = 32'hFFFF_FF80; sv[2] = 32'h1234_5678; sv[3] = 32'h8000_0001;
    sv[4] = 32'h7FFF_FFFF; sv[5] = 32'h0F0F_F0F0; sv[6] = 32'hFFFF_FFFE; sv[7] = 32'h0000_0005;
    for (int i = 0; i < 8; i++) dv[i] = 32'h5555_0000 | 32'(i);
    load_all();
    for (int k = 0; k < 2; k++)
      for (int o = 0; o < 8; o++) begin
        run(3'(o), ms[k], 1'b0, 1'b0);
        chk(result == m_fold(3'(o), ms[k]), $sformatf("R2 op %0d mask %h", o, ms[k]),
            result, m_fold(3'(o), ms[k]));
      end
  endtask

  task automatic t_cond();
    logic [7:0] m = 8'h0F;
    sv[0] = 32'd5; sv[1] = 32'hFFFF_FFF6; sv[2] = 32'd5; sv[3] = 32'd3;
    sv[4] = 32'd0; sv[5] = 32'd0; sv[6] = 32'd0; sv[7] = 32'd0;
    for (int i = 0; i < 8; i++) load(1'b0, i, sv[i]);
    run(3'd0, m, 1'b1, 1'b0);
    chk(cond == m_cond(3'd0, m, 0), "R4 any-mode cond", {28'd0, cond}, {28'd0, m_cond(3'd0, m, 0)});
    run(3'd0, m, 1'b1, 1'b1);
    chk(cond == m_cond(3'd0, m, 1), "R5 all-mode cond", {28'd0, cond}, {28'd0, m_cond(3'd0, m, 1)});
    run(3'd5, m, 1'b1, 1'b1);
    chk(cond == m_cond(3'd5, m, 1), "R5 all-mode cond max", {28'd0, cond}, {28'd0, m_cond(3'd5, m, 1)});
    run(3'd0, m, 1'b0, 1'b1);
    chk(cond == 4'd0, "R6 record off", {28'd0, cond}, 32'd0);
  endtask

  task automatic t_empty();
    logic [31:0] v;
    for (int i = 0; i < 8; i++) dv[i] = 32'hA5A5_0000 | 32'(i);
    for (int i = 0; i < 8; i++) load(1'b1, i, dv[i]);
    run(3'd0, 8'h00, 1'b1, 1'b0);
    chk(n_cyc == 1, "R7 empty completes in one cycle", 32'(n_cyc), 32'd1);
    chk(cond == 4'd0 && result == 32'd0, "R7 empty cond/result", result, 32'd0);
    for (int i = 0; i < 8; i++) begin
      read_dst(i, v);
      chk(v == dv[i], "R7 empty writes nothing", v, dv[i]);
    end
  endtask

  task automatic t_irq();
    logic [7:0] m = 8'hE6;
    logic [2:0] so, dof;
    logic [31:0] v;
    int guard;
    for (int i = 0; i < 8; i++) begin
      sv[i] = 32'h11 * (i + 3);
      dv[i] = 32'hC0DE_0000 | 32'(i);
    end
    load_all();
    @(negedge clk);
    start = 1'b1; op = 3'd3; mask = m; rec = 1'b1; all_mode = 1'b0;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    irq = 1'b1;
    @(negedge clk);
    irq = 1'b0;
    chk(halted && !busy, "R8 halted after irq", {30'd0, halted, busy}, 32'd2);
    so = src_off; dof = dst_off;
    chk(dof == 3'd1, "R8 dst_off saved", {29'd0, dof}, 32'd1);
    repeat (4) @(negedge clk);
    chk(src_off == so && dst_off == dof, "R8 offsets frozen", {26'd0, src_off, dst_off}, {26'd0, so, dof});
    chk(!done, "R8 no done while halted", {31'd0, done}, 32'd0);
    resume = 1'b1;
    @(negedge clk);
    resume = 1'b0;
    guard = 0;
    while (!done && guard < 50) begin
      @(negedge clk);
      guard++;
    end
    chk(result == m_fold(3'd3, m), "R8 resumed result", result, m_fold(3'd3, m));
    chk(cond == m_cond(3'd3, m, 0), "R8 resumed cond", {28'd0, cond}, {28'd0, m_cond(3'd3, m, 0)});
    read_dst(1, v);
    chk(v == m_fold(3'd3, m), "R1 resumed dst", v, m_fold(3'd3, m));
  endtask

  task automatic t_busy_ignore();
    logic [7:0] m = 8'hFF;
    logic [31:0] v;
    for (int i = 0; i < 8; i++) begin
      sv[i] = 32'(i + 1);
      dv[i] = 32'd0;
    end
    load_all();
    @(negedge clk);
    start = 1'b1; op = 3'd0; mask = m; rec = 1'b0; all_mode = 1'b0;
    @(negedge clk);
    start = 1'b1; op = 3'd1; mask = 8'h01;
    ld_en = 1'b1; ld_dst = 1'b0; ld_idx = 3'd7; ld_data = 32'hFFFF_0000;
    @(negedge clk);
    start = 1'b0; ld_en = 1'b0;
    while (!done) @(negedge clk);
    chk(result == 32'd36, "R9 start/load ignored while busy", result, 32'd36);
    @(negedge clk);
    rd_dst = 1'b0; rd_idx = 3'd7;
    #0.1;
    v = rd_data;
    chk(v == 32'd8, "R9 source kept while busy", v, 32'd8);
  endtask

  task automatic finish_up();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic_add();
    t_ops();
    t_cond();
    t_empty();
    t_irq();
    t_busy_ignore();
    finish_up();
  end
endmodule